// File: doc/BRIEF.md
# SDRAM Burst Termination Sequencer

This block sits at the command front end of a single-data-rate SDRAM controller. It takes one request at a time from a host over a valid/ready handshake. Each request is a read start, a write start, a burst stop, a precharge or a mode load. The block turns the request into a command on the SDRAM command bus. It counts the beats of the burst in flight and produces a read-data-valid strobe that trails the column beats by the programmed CAS latency. It also reports, cycle by cycle, whether the write data offered by the host is being taken.

A burst can be cut short in two ways: by a burst-stop command or by a precharge. A precharge that lands in the middle of a write first masks the remaining beats on the byte masks, then waits out the last-data-to-precharge spacing. Burst length and CAS latency live in a shadow copy that changes only when a mode load is actually issued. If the bank tracker reports that some bank is still open, the block puts a precharge-all in front of the mode load. While any spacing rule is pending, the handshake holds requests back, so none is lost or reordered.

Top module: `sdr_burst_seq`

## Requirements
- R1: A read or write request accepted at a clock edge puts its command on `sdr_cmd` in the next cycle. The burst then runs for 1, 2, 4 or 8 beats, for shadow burst-length code 0, 1, 2 or 3. `wr_take` is high on every write beat, starting in the write-command cycle. Host op codes: read=0, write=1, stop=2, precharge=3, mode=4. Command codes: NOP=0, READ=1, WRITE=2, BSTOP=3, PRECH=4, MODE=5.
- R2: `rd_valid` is high exactly CL cycles after each read beat, where CL is 2 when the shadow `mode_cl3` is 0 and 3 when it is 1. The first beat is in the read-command cycle.
- R3: A burst stop during a write ends `wr_take` in the BSTOP cycle. The last beat taken is in the cycle just before it.
- R4: A burst stop during a read leaves exactly CL−1 `rd_valid` beats after the BSTOP cycle.
- R5: A precharge during a read ends output the same way: exactly CL−1 `rd_valid` beats after the PRECH cycle.
- R6: A precharge accepted while the write burst still has beats left after the current one does three things. `wr_take` drops in the next cycle. All `sdr_dqm` bits are then high for T_RDL cycles with NOP on the bus, followed by PRECH with the masks still high. The masks fall in the cycle after PRECH.
- R7: A precharge issued with no write beats pending appears in the cycle after acceptance. The next command comes no earlier than T_RP cycles after it, and `req_ready` is low in the PRECH cycle when T_RP > 1.
- R8: A mode request accepted while `all_banks_idle` is high issues MODE in the next cycle. `mode_bl` and `mode_cl3` take the requested values in that same cycle, and the next command comes T_MRD (2) cycles after MODE or later.
- R9: A mode request accepted while `all_banks_idle` is low issues PRECH in the next cycle, then MODE exactly T_RP cycles after that PRECH.
- R10: A request held valid while a spacing rule is pending is stalled by `req_ready` low and later issued unchanged, in order.
- R11: After reset the block drives NOP, all masks low, `rd_valid` and `wr_take` low and `req_ready` high. The shadow mode after reset is burst-length code 2 (4 beats) with CL 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_op | input | 3 | Host op code (see R1) |
| req_bl | input | 2 | Burst-length code for a mode request |
| req_cl3 | input | 1 | CAS latency select for a mode request (1 = CL3) |
| all_banks_idle | input | 1 | Bank tracker reports every bank precharged |
| sdr_cmd | output | 3 | Command issued this cycle (see R1) |
| sdr_dqm | output | BYTES | Byte masks, high = beat masked |
| rd_valid | output | 1 | Read data on the bus is valid |
| wr_take | output | 1 | Write data is taken this cycle |
| mode_bl | output | 2 | Shadow burst-length code |
| mode_cl3 | output | 1 | Shadow CAS latency select |

## Verification
The burst counter and the latency tail are swept over all eight burst-length and CAS-latency pairs. Each pair is loaded through a mode request, then measured with an uncut read and an uncut write, which separates beat counting from latency placement. Cut-short bursts are tried three ways: a stop on a write, a stop on a read at both latencies, and a precharge on a read. Because the read tail must come out the same after a stop and after a precharge, an error in the clearing path shows up in one case but not the other. A precharge landing mid-write is what separates the masking path from the plain one. Mode requests with banks idle and with banks open, each followed at once by another request, show that the spacing stalls hold back a request without dropping it.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  localparam int MAX_BL_LOG = 3;
  localparam int BEAT_W     = MAX_BL_LOG + 1;
  localparam int MAX_CL     = 3;

  typedef enum logic [2:0] {
    OP_RD   = 3'd0,
    OP_WR   = 3'd1,
    OP_STOP = 3'd2,
    OP_PRE  = 3'd3,
    OP_MODE = 3'd4
  } host_op_e;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_BSTOP = 3'd3,
    CMD_PRECH = 3'd4,
    CMD_MODE  = 3'd5
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_MASK    = 2'd1,
    ST_PREWAIT = 2'd2
  } seq_state_e;

  // Beats in a burst for a burst-length code.
  function automatic logic [BEAT_W-1:0] bl_beats(input logic [1:0] code);
    return BEAT_W'(1) << code;
  endfunction

  // CAS latency in clocks for the latency select.
  function automatic int unsigned cl_cycles(input logic cl3);
    return cl3 ? 3 : 2;
  endfunction

endpackage

// File: rtl/sdr_burst_cnt.sv
module sdr_burst_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         clear,
  input  logic [W-1:0] len,
  output logic [W-1:0] left
);

  always_ff @(posedge clk) begin
    if (rst)              left <= '0;
    else if (load)        left <= len;
    else if (clear)       left <= '0;
    else if (left != '0)  left <= left - W'(1);
  end

endmodule

// File: rtl/sdr_rd_tail.sv
module sdr_rd_tail
  import sdr_seq_pkg::*;
#(
  parameter int DEPTH = MAX_CL
) (
  input  logic clk,
  input  logic rst,
  input  logic beat,
  input  logic cl3,
  output logic valid
);

  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH-1:0] pipe_d;

  // A beat enters at the tap that leaves it CL cycles from the bus.
  always_comb begin
    pipe_d = pipe_q >> 1;
    pipe_d[cl_cycles(cl3) - 1] = pipe_d[cl_cycles(cl3) - 1] | beat;
  end

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= pipe_d;
  end

  assign valid = pipe_q[0];

endmodule

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
  import sdr_seq_pkg::*;
#(
  parameter int T_RP  = 2,
  parameter int T_RDL = 1,
  parameter int T_MRD = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [1:0]        req_bl,
  input  logic              req_cl3,
  input  logic              all_banks_idle,
  input  logic              wr_more,
  output logic              req_ready,
  output logic              req_accept,
  output logic              rd_load,
  output logic              wr_load,
  output logic              rd_clear,
  output logic              wr_clear,
  output logic              intr_wr,
  output logic              mrs_pre,
  output logic [BEAT_W-1:0] burst_len,
  output logic [2:0]        cmd,
  output logic              dqm_all,
  output logic [1:0]        mode_bl,
  output logic              mode_cl3
);

  localparam int WAIT_W = $clog2(T_RP + T_MRD + T_RDL + 1);

  seq_state_e        state_q;
  logic [WAIT_W-1:0] wait_q;
  logic [WAIT_W-1:0] mask_q;
  sdr_cmd_e          cmd_q;
  logic              dqm_q;
  logic [1:0]        bl_q, pend_bl_q;
  logic              cl3_q, pend_cl3_q;
  host_op_e          op;
  logic              kill;

  always_comb begin
    op         = host_op_e'(req_op);
    req_ready  = (state_q == ST_RUN) && (wait_q == '0);
    req_accept = req_valid && req_ready;
    rd_load    = req_accept && (op == OP_RD);
    wr_load    = req_accept && (op == OP_WR);
    kill       = req_accept && (op == OP_STOP || op == OP_PRE || op == OP_MODE);
    rd_clear   = kill || wr_load;
    wr_clear   = kill || rd_load;
    intr_wr    = req_accept && (op == OP_PRE) && wr_more;
    mrs_pre    = req_accept && (op == OP_MODE) && !all_banks_idle;
    burst_len  = bl_beats(bl_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      wait_q     <= '0;
      mask_q     <= '0;
      cmd_q      <= CMD_NOP;
      dqm_q      <= 1'b0;
      bl_q       <= 2'd2;
      cl3_q      <= 1'b0;
      pend_bl_q  <= '0;
      pend_cl3_q <= 1'b0;
    end else begin
      cmd_q <= CMD_NOP;
      dqm_q <= 1'b0;
      if (wait_q != '0) wait_q <= wait_q - WAIT_W'(1);
      case (state_q)
        ST_RUN: if (req_accept) begin
          case (op)
            OP_RD:   cmd_q <= CMD_READ;
            OP_WR:   cmd_q <= CMD_WRITE;
            OP_STOP: cmd_q <= CMD_BSTOP;
            OP_PRE: begin
              if (wr_more) begin
                state_q <= ST_MASK;
                mask_q  <= WAIT_W'(T_RDL);
                dqm_q   <= 1'b1;
              end else begin
                cmd_q  <= CMD_PRECH;
                wait_q <= WAIT_W'(T_RP - 1);
              end
            end
            OP_MODE: begin
              if (all_banks_idle) begin
                cmd_q  <= CMD_MODE;
                bl_q   <= req_bl;
                cl3_q  <= req_cl3;
                wait_q <= WAIT_W'(T_MRD - 1);
              end else begin
                cmd_q      <= CMD_PRECH;
                wait_q     <= WAIT_W'(T_RP - 1);
                pend_bl_q  <= req_bl;
                pend_cl3_q <= req_cl3;
                state_q    <= ST_PREWAIT;
              end
            end
            default: ;
          endcase
        end
        ST_MASK: begin
          dqm_q <= 1'b1;
          if (mask_q == WAIT_W'(1)) begin
            cmd_q   <= CMD_PRECH;
            wait_q  <= WAIT_W'(T_RP - 1);
            state_q <= ST_RUN;
          end else begin
            mask_q <= mask_q - WAIT_W'(1);
          end
        end
        ST_PREWAIT: if (wait_q == '0) begin
          cmd_q   <= CMD_MODE;
          bl_q    <= pend_bl_q;
          cl3_q   <= pend_cl3_q;
          wait_q  <= WAIT_W'(T_MRD - 1);
          state_q <= ST_RUN;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign cmd      = cmd_q;
  assign dqm_all  = dqm_q;
  assign mode_bl  = bl_q;
  assign mode_cl3 = cl3_q;

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_seq_pkg::*;
#(
  parameter int BYTES = 4,
  parameter int T_RP  = 2,
  parameter int T_RDL = 1,
  parameter int T_MRD = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [1:0]       req_bl,
  input  logic             req_cl3,
  input  logic             all_banks_idle,
  output logic [2:0]       sdr_cmd,
  output logic [BYTES-1:0] sdr_dqm,
  output logic             rd_valid,
  output logic             wr_take,
  output logic [1:0]       mode_bl,
  output logic             mode_cl3
);

  // Named internal events, also observed by the bound checker.
  logic              req_accept;
  logic              rd_load, wr_load, rd_clear, wr_clear;
  logic              intr_wr, mrs_pre;
  logic              dqm_all;
  logic              rd_beat, wr_more;
  logic [BEAT_W-1:0] burst_len;
  logic [BEAT_W-1:0] rd_left, wr_left;

  sdr_seq_ctrl #(.T_RP(T_RP), .T_RDL(T_RDL), .T_MRD(T_MRD)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_bl(req_bl), .req_cl3(req_cl3), .all_banks_idle(all_banks_idle),
    .wr_more(wr_more), .req_ready(req_ready), .req_accept(req_accept),
    .rd_load(rd_load), .wr_load(wr_load), .rd_clear(rd_clear),
    .wr_clear(wr_clear), .intr_wr(intr_wr), .mrs_pre(mrs_pre),
    .burst_len(burst_len), .cmd(sdr_cmd), .dqm_all(dqm_all),
    .mode_bl(mode_bl), .mode_cl3(mode_cl3)
  );

  sdr_burst_cnt #(.W(BEAT_W)) u_rd_cnt (
    .clk(clk), .rst(rst), .load(rd_load), .clear(rd_clear),
    .len(burst_len), .left(rd_left)
  );

  sdr_burst_cnt #(.W(BEAT_W)) u_wr_cnt (
    .clk(clk), .rst(rst), .load(wr_load), .clear(wr_clear),
    .len(burst_len), .left(wr_left)
  );

  assign rd_beat = (rd_left != '0);
  assign wr_take = (wr_left != '0);
  assign wr_more = (wr_left > BEAT_W'(1));

  sdr_rd_tail #(.DEPTH(MAX_CL)) u_tail (
    .clk(clk), .rst(rst), .beat(rd_beat), .cl3(mode_cl3), .valid(rd_valid)
  );

  assign sdr_dqm = {BYTES{dqm_all}};

endmodule

// File: rtl/sdr_burst_seq_chk.sv
module sdr_burst_seq_chk
  import sdr_seq_pkg::*;
#(
  parameter int BYTES = 4,
  parameter int T_RP  = 2,
  parameter int T_MRD = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic [2:0]       sdr_cmd,
  input logic [BYTES-1:0] sdr_dqm,
  input logic             rd_valid,
  input logic             wr_take,
  input logic             mode_cl3,
  input logic             rd_beat,
  input logic             intr_wr,
  input logic             mrs_pre
);

  // R2: each read beat surfaces after the selected latency.
  p_read_lat2_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_beat && !mode_cl3) |-> ##2 rd_valid);
  p_read_lat3_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_beat && mode_cl3) |-> ##3 rd_valid);

  // R3: no write data taken in a burst-stop cycle.
  p_stop_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    (sdr_cmd == CMD_BSTOP) |-> !wr_take);

  // R6: an interrupted write is masked at once, with NOP on the bus.
  p_mask_after_intr_r6: assert property (@(posedge clk) disable iff (rst)
    intr_wr |=> (sdr_dqm == {BYTES{1'b1}} && !wr_take && sdr_cmd == CMD_NOP));

  // R9: an open bank forces a precharge before the mode load.
  p_prech_before_mode_r9: assert property (@(posedge clk) disable iff (rst)
    mrs_pre |=> (sdr_cmd == CMD_PRECH));

  generate
    if (T_MRD >= 2) begin : g_mrd
      // R8: bus quiet in the cycle after a mode load.
      p_mode_gap_r8: assert property (@(posedge clk) disable iff (rst)
        (sdr_cmd == CMD_MODE) |=> (sdr_cmd == CMD_NOP));
    end
    if (T_RP >= 2) begin : g_rp
      // R7: no request accepted in a precharge cycle.
      p_ready_after_prech_r7: assert property (@(posedge clk) disable iff (rst)
        (sdr_cmd == CMD_PRECH) |-> !req_ready);
    end
  endgenerate

endmodule

bind sdr_burst_seq sdr_burst_seq_chk #(.BYTES(BYTES), .T_RP(T_RP), .T_MRD(T_MRD)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .sdr_cmd(sdr_cmd),
  .sdr_dqm(sdr_dqm), .rd_valid(rd_valid), .wr_take(wr_take),
  .mode_cl3(mode_cl3), .rd_beat(rd_beat), .intr_wr(intr_wr),
  .mrs_pre(mrs_pre)
);

// File: tb/tb_sdr_burst_seq.sv
module tb_sdr_burst_seq;

  localparam int CLK_P = 10;
  localparam int BYTES = 4;
  localparam int T_RP  = 2;
  localparam int T_RDL = 1;
  localparam int T_MRD = 2;

  // {bl code, cl3, expected beats, expected latency}
  localparam logic [8:0] VEC [0:7] = '{
    {2'd0, 1'b0, 4'd1, 2'd2}, {2'd1, 1'b0, 4'd2, 2'd2},
    {2'd2, 1'b0, 4'd4, 2'd2}, {2'd3, 1'b0, 4'd8, 2'd2},
    {2'd0, 1'b1, 4'd1, 2'd3}, {2'd1, 1'b1, 4'd2, 2'd3},
    {2'd2, 1'b1, 4'd4, 2'd3}, {2'd3, 1'b1, 4'd8, 2'd3}
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             req_valid, req_ready;
  logic [2:0]       req_op;
  logic [1:0]       req_bl;
  logic             req_cl3;
  logic             all_banks_idle;
  logic [2:0]       sdr_cmd;
  logic [BYTES-1:0] sdr_dqm;
  logic             rd_valid, wr_take;
  logic [1:0]       mode_bl;
  logic             mode_cl3;

  sdr_burst_seq #(.BYTES(BYTES), .T_RP(T_RP), .T_RDL(T_RDL), .T_MRD(T_MRD)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_bl(req_bl), .req_cl3(req_cl3),
    .all_banks_idle(all_banks_idle), .sdr_cmd(sdr_cmd), .sdr_dqm(sdr_dqm),
    .rd_valid(rd_valid), .wr_take(wr_take), .mode_bl(mode_bl),
    .mode_cl3(mode_cl3)
  );

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0, n_rv = 0, n_wb = 0, n_dq = 0;
  int last_rv = 0, last_wb = 0, last_dq = 0, last_pre = 0, last_bst = 0, last_mrs = 0;
  int checks = 0, fails = 0;

  // Event monitor, sampled mid-cycle.
  always @(negedge clk) begin
    if (!rst) begin
      cyc = cyc + 1;
      if (rd_valid)       begin n_rv = n_rv + 1; last_rv = cyc; end
      if (wr_take)        begin n_wb = n_wb + 1; last_wb = cyc; end
      if (sdr_dqm != '0)  begin n_dq = n_dq + 1; last_dq = cyc; end
      if (sdr_cmd == 3'd4) last_pre = cyc;
      if (sdr_cmd == 3'd3) last_bst = cyc;
      if (sdr_cmd == 3'd5) last_mrs = cyc;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Present a request, wait for the handshake; returns in the command cycle.
  task automatic issue(input logic [2:0] op, input logic [1:0] bl, input logic cl3,
                       output int t);
    req_op = op; req_bl = bl; req_cl3 = cl3; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    t = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; fails++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int t, t2, b_rv, b_wb, b_dq;
    rst = 1'b1; req_valid = 1'b0; req_op = '0; req_bl = '0; req_cl3 = 1'b0;
    all_banks_idle = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R11 reset state
    chk("R11 cmd", int'(sdr_cmd), 0);
    chk("R11 dqm", int'(sdr_dqm), 0);
    chk("R11 rd_valid/wr_take", int'({rd_valid, wr_take}), 0);
    chk("R11 ready", int'(req_ready), 1);
    chk("R11 mode", int'({mode_cl3, mode_bl}), 2);

    // R1/R2 sweep of burst length and latency
    for (int i = 0; i < 8; i++) begin
      issue(3'd4, VEC[i][8:7], VEC[i][6], t);
      chk("R8 mode load", int'({mode_cl3, mode_bl}), int'({VEC[i][6], VEC[i][8:7]}));
      b_rv = n_rv;
      issue(3'd0, 2'd0, 1'b0, t);
      idle(20);
      chk("R1 read beats", n_rv - b_rv, int'(VEC[i][5:2]));
      chk("R2 read last valid", last_rv - t, int'(VEC[i][1:0]) + int'(VEC[i][5:2]) - 1);
      b_wb = n_wb;
      issue(3'd1, 2'd0, 1'b0, t);
      idle(12);
      chk("R1 write beats", n_wb - b_wb, int'(VEC[i][5:2]));
      chk("R1 write last beat", last_wb - t, int'(VEC[i][5:2]) - 1);
    end

    // R3 write burst stop (BL8, CL2)
    issue(3'd4, 2'd3, 1'b0, t);
    b_wb = n_wb;
    issue(3'd1, 2'd0, 1'b0, t);
    idle(2);
    issue(3'd2, 2'd0, 1'b0, t2);
    idle(10);
    chk("R3 beats before stop", n_wb - b_wb, 3);
    chk("R3 last beat before stop", last_bst - last_wb, 1);
    chk("R3 stop timing", t2 - t, 3);

    // R4 read burst stop, CL2
    b_rv = n_rv;
    issue(3'd0, 2'd0, 1'b0, t);
    idle(3);
    issue(3'd2, 2'd0, 1'b0, t2);
    idle(10);
    chk("R4 CL2 total beats", n_rv - b_rv, 4);
    chk("R4 CL2 tail after stop", last_rv - last_bst, 1);

    // R4 read burst stop, CL3
    issue(3'd4, 2'd3, 1'b1, t);
    b_rv = n_rv;
    issue(3'd0, 2'd0, 1'b0, t);
    idle(3);
    issue(3'd2, 2'd0, 1'b0, t2);
    idle(10);
    chk("R4 CL3 total beats", n_rv - b_rv, 4);
    chk("R4 CL3 tail after stop", last_rv - last_bst, 2);

    // R5 read cut by precharge, CL3
    b_rv = n_rv;
    issue(3'd0, 2'd0, 1'b0, t);
    idle(1);
    issue(3'd3, 2'd0, 1'b0, t2);
    idle(10);
    chk("R5 total beats", n_rv - b_rv, 2);
    chk("R5 tail after precharge", last_rv - last_pre, 2);

    // R7 precharge spacing, R10 stalled request kept
    issue(3'd3, 2'd0, 1'b0, t);
    chk("R7 precharge cycle", int'(sdr_cmd), 4);
    chk("R7 ready low", int'(req_ready), 0);
    issue(3'd2, 2'd0, 1'b0, t2);
    chk("R7 next command spacing", t2 - t, T_RP);
    chk("R10 stalled stop issued", int'(sdr_cmd), 3);
    idle(4);

    // R6 write interrupted by precharge (BL8)
    issue(3'd4, 2'd3, 1'b0, t);
    idle(2);
    b_wb = n_wb; b_dq = n_dq;
    issue(3'd1, 2'd0, 1'b0, t);
    idle(2);
    issue(3'd3, 2'd0, 1'b0, t2);
    chk("R6 mask in first cycle", int'(sdr_dqm), 15);
    chk("R6 no write in mask cycle", int'(wr_take), 0);
    idle(10);
    chk("R6 beats written", n_wb - b_wb, 3);
    chk("R6 precharge timing", last_pre - t, 3 + T_RDL);
    chk("R6 masked cycles", n_dq - b_dq, T_RDL + 1);
    chk("R6 mask ends with precharge", last_dq, last_pre);

    // R8 mode with idle banks, following request stalled
    issue(3'd4, 2'd1, 1'b1, t);
    chk("R8 mode cmd", int'(sdr_cmd), 5);
    chk("R8 mode outputs", int'({mode_cl3, mode_bl}), 5);
    chk("R10 ready low after mode", int'(req_ready), 0);
    issue(3'd2, 2'd0, 1'b0, t2);
    chk("R8 spacing after mode", t2 - t, T_MRD);
    idle(4);

    // R9 mode with an open bank; R10 request queued behind it
    all_banks_idle = 1'b0;
    issue(3'd4, 2'd0, 1'b0, t);
    all_banks_idle = 1'b1;
    chk("R9 precharge first", int'(sdr_cmd), 4);
    issue(3'd2, 2'd0, 1'b0, t2);
    idle(4);
    chk("R9 mode after tRP", last_mrs - t, T_RP);
    chk("R9 mode outputs", int'({mode_cl3, mode_bl}), 0);
    chk("R10 stop after mode spacing", last_bst - last_mrs, T_MRD);

    summary();
    $finish;
  end

endmodule